// File: doc/BRIEF.md
# Banked Register Window Decoder

This block is the host-facing register access unit of a peripheral that occupies a 16-byte I/O window. The host supplies a 4-bit byte offset, read and write strobes, byte enables and a width-mode input. The block steers each access to the register storage behind it and returns registered read data.

Offsets 0x0 to 0xD hold seven 16-bit registers. This set of registers is replicated in four banks. The word at offset 0xE is a bank-select register. It is present in every bank, and its low two bits choose the bank that offsets 0x0 to 0xD reach.

The window can run as a 16-bit space, where byte enables pick the lanes. It can also run as an 8-bit space, where the low address bit picks the lane. A byte write to one half of a word leaves the other half untouched, so two independent byte-wide registers can share one word. A synchronous hard reset loads every register with a default value that can be computed, and it selects bank 0.

Top module: `bankreg_window`

## Requirements
- R1: Word index addr[3:1] values 0 to 6 reach registers of the currently selected bank. Index 7 (offset 0xE/0xF) reaches the bank-select register whichever bank is selected.
- R2: The four banks hold separate storage: a write while bank n is selected never changes a register of any other bank.
- R3: A write that enables the low byte lane of offset 0xE loads wdata-lane bits 1:0 into the bank select. Later accesses to indices 0 to 6 then use the new bank.
- R4: The bank-select word reads as 16'h3300 with the bank number in bits 1:0. Writes to bits 15:2, including any write to the high lane (offset 0xF), have no effect.
- R5: A cycle with rst high selects bank 0, clears rdata and rdata_valid, and sets register w of bank b to 16'h1000*(b+1) + 16'h0011*w.
- R6: In 16-bit mode (wide_mode=1), be=2'b11 writes the full wdata word, and a read returns the full 16-bit word. addr[0] is ignored.
- R7: In 16-bit mode, be=2'b01 writes only bits 7:0 from wdata[7:0], and be=2'b10 writes only bits 15:8 from wdata[15:8]. The other byte keeps its value.
- R8: In 8-bit mode (wide_mode=0), be is ignored. addr[0]=0 selects bits 7:0 and addr[0]=1 selects bits 15:8. Write data comes from wdata[7:0], and read data appears on rdata[7:0] with rdata[15:8]=0.
- R9: rdata_valid is high exactly in the cycle after a cycle with rd_en high. rdata changes only on such reads or on reset, and otherwise holds.
- R10: When rd_en and wr_en are both high, the read returns the contents from before the write, including the old bank.
- R11: In 16-bit mode, a write with be=2'b00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| addr | input | 4 | Byte offset within the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| be | input | 2 | Byte-lane enables, 16-bit mode only |
| wide_mode | input | 1 | 1 = 16-bit window, 0 = 8-bit window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rdata_valid | output | 1 | High the cycle after a read |

## Verification
A corrupted bank select would show as wrong data on the very next read of any offset below 0xE. A read of 0xE would also expose it directly. A byte lane that leaks would only show when the untouched half of that word is read back, so the bench reads both lanes after every byte write. It also rereads all four banks after a burst of writes to catch cross-bank leakage. Since rdata is compared on every cycle, a missed or extra update becomes visible one cycle after the offending strobe.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int NUM_BANKS  = 4;
  localparam int REGS_PER_BANK = 7;
  localparam int WIDX_W     = ADDR_W - 1;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int LANES      = DATA_W / 8;
  localparam logic [WIDX_W-1:0] SEL_IDX = WIDX_W'((1 << WIDX_W) - 1);
  localparam logic [DATA_W-1:0] SEL_FIXED = 16'h3300;

  function automatic logic [DATA_W-1:0] reg_default(input int b, input int w);
    return DATA_W'(((b + 1) << 12) + (w * 17));
  endfunction
endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
  import bankreg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      be,
  input  logic            wide_mode,
  input  logic [DW-1:0]   wdata,
  output logic [AW-2:0]   word_idx,
  output logic [1:0]      lane_en,
  output logic            odd_lane,
  output logic [DW-1:0]   wdata_lanes
);
  always_comb begin
    word_idx = addr[AW-1:1];
    odd_lane = addr[0];
    if (wide_mode) begin
      lane_en     = be;
      wdata_lanes = wdata;
    end else begin
      lane_en     = addr[0] ? 2'b10 : 2'b01;
      wdata_lanes = {wdata[7:0], wdata[7:0]};
    end
  end
endmodule

// File: rtl/bankreg_bank.sv
module bankreg_bank
  import bankreg_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int NREGS   = REGS_PER_BANK,
  parameter int IW      = WIDX_W,
  parameter int DW      = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    lane_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);
  localparam int NL = DW / 8;
  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NREGS; w++) regs[w] <= reg_default(BANK_ID, w);
    end else if (we) begin
      for (int w = 0; w < NREGS; w++)
        for (int l = 0; l < NL; l++)
          if (int'(idx) == w && lane_en[l]) regs[w][l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end

  always_comb begin
    rword = '0;
    for (int w = 0; w < NREGS; w++)
      if (int'(idx) == w) rword = regs[w];
  end
endmodule

// File: rtl/bankreg_select.sv
module bankreg_select
  import bankreg_pkg::*;
#(
  parameter int BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          low_lane,
  input  logic [BW-1:0] wbank,
  output logic [BW-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst)                 bank <= '0;
    else if (we && low_lane) bank <= wbank;
  end
endmodule

// File: rtl/bankreg_window.sv
module bankreg_window
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        be,
  input  logic              wide_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);
  logic [WIDX_W-1:0] word_idx;
  logic [1:0]        lane_en;
  logic              odd_lane;
  logic [DATA_W-1:0] wd_lanes;
  logic [BANK_W-1:0] cur_bank;
  logic              sel_hit;
  logic [DATA_W-1:0] bank_word [NUM_BANKS];
  logic [DATA_W-1:0] rd_word;

  bankreg_decode u_dec (
    .addr(addr), .be(be), .wide_mode(wide_mode), .wdata(wdata),
    .word_idx(word_idx), .lane_en(lane_en), .odd_lane(odd_lane),
    .wdata_lanes(wd_lanes)
  );

  assign sel_hit = (word_idx == SEL_IDX);

  bankreg_select u_sel (
    .clk(clk), .rst(rst), .we(wr_en && sel_hit), .low_lane(lane_en[0]),
    .wbank(wd_lanes[BANK_W-1:0]), .bank(cur_bank)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bankreg_bank #(.BANK_ID(g)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_en && !sel_hit && (cur_bank == BANK_W'(g))),
      .idx(word_idx), .lane_en(lane_en), .wdata(wd_lanes),
      .rword(bank_word[g])
    );
  end

  always_comb begin
    if (sel_hit) rd_word = SEL_FIXED | DATA_W'(cur_bank);
    else         rd_word = bank_word[cur_bank];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= rd_en;
      if (rd_en) begin
        if (wide_mode) rdata <= rd_word;
        else           rdata <= {8'h00, odd_lane ? rd_word[15:8] : rd_word[7:0]};
      end
    end
  end
endmodule

// File: rtl/bankreg_window_chk.sv
module bankreg_window_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  addr,
  input logic        rd_en,
  input logic        wide_mode,
  input logic [15:0] rdata,
  input logic        rdata_valid
);
  assert_valid_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rdata_valid);
  assert_valid_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |-> $past(rd_en));
  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rdata_valid && !$past(wide_mode)) |-> (rdata[15:8] == 8'h00));
  assert_select_fixed_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (rdata_valid && $past(wide_mode) && ($past(addr[3:1]) == 3'd7)) |->
      (rdata[15:2] == 14'h0CC0));
endmodule

bind bankreg_window bankreg_window_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wide_mode(wide_mode),
  .rdata(rdata), .rdata_valid(rdata_valid)
);

// File: tb/bankreg_window_tb.sv
`timescale 1ns/1ps
module bankreg_window_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0, wide_mode = 1'b1;
  logic [1:0] be = 2'b11;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rdata_valid;

  always #2 clk = ~clk;

  bankreg_window u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .be(be), .wide_mode(wide_mode), .wdata(wdata),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );

  int checks = 0, fails = 0;
  bit chk_on = 0, done = 0;
  string cur_tag = "R5", exp_tag = "R5";
  logic [15:0] m_regs [4][7];
  int m_bank;
  logic [15:0] exp_rdata;
  logic exp_valid;

  function automatic logic [15:0] m_word(input int w);
    if (w == 7) return 16'h3300 + 16'(m_bank);
    return m_regs[m_bank][w];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 4; b++)
        for (int w = 0; w < 7; w++) m_regs[b][w] = 16'h1000 * 16'(b + 1) + 16'h0011 * 16'(w);
      m_bank = 0; exp_rdata = '0; exp_valid = 0; exp_tag = "R5";
    end else begin
      int w;
      logic [1:0] ln;
      logic [15:0] d;
      w = int'(addr[3:1]);
      exp_tag = cur_tag;
      exp_valid = rd_en;
      if (rd_en) begin
        if (wide_mode) exp_rdata = m_word(w);
        else exp_rdata = {8'h00, addr[0] ? m_word(w) >> 8 : m_word(w) & 16'h00FF};
      end
      if (wr_en) begin
        ln = wide_mode ? be : (addr[0] ? 2'b10 : 2'b01);
        d  = wide_mode ? wdata : {wdata[7:0], wdata[7:0]};
        if (w == 7) begin
          if (ln[0]) m_bank = int'(d[1:0]);
        end else begin
          if (ln[0]) m_regs[m_bank][w][7:0]  = d[7:0];
          if (ln[1]) m_regs[m_bank][w][15:8] = d[15:8];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (rdata_valid !== exp_valid || rdata !== exp_rdata) begin
        fails++;
        $display("FAIL %s: rdata=%h valid=%b expected rdata=%h valid=%b",
                 exp_tag, rdata, rdata_valid, exp_rdata, exp_valid);
      end
    end
  end

  task automatic acc(input bit rd, input bit wr, input logic [3:0] a,
                     input logic [1:0] b, input bit wide, input logic [15:0] d,
                     input string tag);
    @(negedge clk); #1;
    rd_en = rd; wr_en = wr; addr = a; be = b; wide_mode = wide; wdata = d; cur_tag = tag;
  endtask

  task automatic idle(input string tag);
    acc(0, 0, 4'h0, 2'b00, 1, 16'h0000, tag);
  endtask

  task automatic read_bank_all(input string tag);
    for (int w = 0; w < 8; w++) acc(1, 0, 4'(w * 2), 2'b11, 1, 16'h0, tag);
  endtask

  task automatic sel(input int b, input string tag);
    acc(0, 1, 4'hE, 2'b11, 1, 16'(b), tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    chk_on = 1;
    idle("R9");
    read_bank_all("R5");                    // R1 R5: bank 0 defaults and select word
    for (int b = 1; b < 4; b++) begin       // R3: switch banks, read defaults
      sel(b, "R3");
      read_bank_all("R3");
    end
    sel(1, "R3");
    acc(0, 1, 4'h2, 2'b11, 1, 16'hBEEF, "R6");
    acc(1, 0, 4'h3, 2'b11, 1, 16'h0, "R6");   // addr[0] ignored in 16-bit mode
    acc(0, 1, 4'h4, 2'b00, 1, 16'hFFFF, "R11");
    acc(1, 0, 4'h4, 2'b11, 1, 16'h0, "R11");
    sel(2, "R3");
    acc(0, 1, 4'h6, 2'b01, 1, 16'h12AB, "R7");
    acc(1, 0, 4'h6, 2'b11, 1, 16'h0, "R7");
    acc(0, 1, 4'h8, 2'b10, 1, 16'hCD34, "R7");
    acc(1, 0, 4'h8, 2'b11, 1, 16'h0, "R7");
    acc(0, 1, 4'hE, 2'b10, 1, 16'hFF03, "R4");  // high lane only: bank unchanged
    acc(1, 0, 4'hE, 2'b11, 1, 16'h0, "R4");
    acc(0, 1, 4'hE, 2'b11, 1, 16'hFFFF, "R4");  // bank 3, upper bits fixed
    acc(1, 0, 4'hE, 2'b11, 1, 16'h0, "R4");
    acc(0, 1, 4'h0, 2'b11, 0, 16'h005A, "R8");  // 8-bit mode, bank 3
    acc(0, 1, 4'h1, 2'b00, 0, 16'hFFA5, "R8");
    acc(1, 0, 4'h0, 2'b00, 0, 16'h0, "R8");
    acc(1, 0, 4'h1, 2'b11, 0, 16'h0, "R8");
    acc(1, 0, 4'hF, 2'b11, 0, 16'h0, "R8");
    acc(0, 1, 4'hE, 2'b00, 0, 16'h0000, "R3");  // 8-bit select bank 0
    acc(0, 1, 4'hF, 2'b00, 0, 16'h0002, "R4");  // odd byte of select ignored
    acc(1, 0, 4'hE, 2'b00, 0, 16'h0, "R4");
    acc(1, 1, 4'hA, 2'b11, 1, 16'h7777, "R10");
    acc(1, 0, 4'hA, 2'b11, 1, 16'h0, "R10");
    acc(1, 1, 4'hE, 2'b11, 1, 16'h0001, "R10");
    acc(1, 0, 4'hE, 2'b11, 1, 16'h0, "R10");
    for (int b = 0; b < 4; b++) begin       // R2: other banks untouched
      sel(b, "R2");
      read_bank_all("R2");
    end
    idle("R9");
    repeat (3) idle("R9");
    @(negedge clk); #1; rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0;
    read_bank_all("R5");
    sel(3, "R5");
    read_bank_all("R5");
    idle("R9");
    idle("R9");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule